// File: doc/BRIEF.md
# Audio Processor Control-Register Bus Slave

This block is the two-wire serial control port of a multi-channel audio processor. A host writes configuration bytes over I2C into nine 8-bit control registers: input selection, loudness, volume, bass/treble, four speaker attenuators and a mute register. All nine are presented in parallel to the signal-path logic. The host may also read back a one-byte status word that reports the soft-mute and zero-crossing-mute conditions of the analog path. That status is re-sampled after each acknowledge, so the host can poll it by clocking further bytes without repeating the address.

A write transfer runs as follows. START, then the device address with R/W = 0, then a subaddress byte, then one or more data bytes, then STOP. In the subaddress byte, the low four bits choose the register and bit 4 selects auto-increment. SCL and SDA are brought into the system clock domain through a synchronizer and are oversampled. The slave acknowledges by driving an open-drain enable. The block also combines the mute register's soft-mute bit with an external active-low pin into a single soft-mute request.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte equal to 1000100 followed by the R/W bit (0x88 write, 0x89 read). Any other address gets no acknowledge, and the slave then ignores the bus until the next STOP, with no register change.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA changes while SCL is low start nothing. A STOP aborts a transfer that is in progress, and a fresh START after it works normally.
- R3: In the subaddress byte, bits 3..0 select register 0..8 and bits 7..5 are ignored. A selector above 8 gets no acknowledge, and the rest of the transfer is ignored.
- R4: With subaddress bit 4 = 1, successive data bytes go to successive registers. A byte arriving after register 8 has been written is discarded and not acknowledged.
- R5: With subaddress bit 4 = 0, every data byte of the transfer overwrites the same register.
- R6: After reset every register reads 0xFE, the soft-mute request is 0 while the pin is high, and SDA is released.
- R7: A read returns a status byte with the soft-mute-active flag at bit 2, the zero-crossing-muted flag at bit 1, and all other bits 0. Bits are sent MSB first.
- R8: After each master acknowledge the status byte is re-sampled for the next byte. A master NACK ends the read, and the slave leaves SDA released until STOP.
- R9: The soft-mute request is high when bit 0 of register 8 is 1 or when the soft-mute pin is low.
- R10: The slave drives SDA low only in the ninth clock after a byte it accepts, and in the data bits of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| smute_n_i | input | 1 | External soft-mute request, active low |
| smute_act_i | input | 1 | Soft-mute-active flag from the analog path |
| zc_muted_i | input | 1 | Zero-crossing-muted flag from the analog path |
| regs_o | output | 72 | Registers 0..8, register n at bits 8n+7..8n |
| smute_req_o | output | 1 | Combined soft-mute request |

## Verification
On every cycle, the assertions check the following: the slave drives SDA only in an acknowledge slot or in a read; it stays silent once it is ignoring a transfer; every STOP returns it to idle; its register pointer and write address never leave 0..8; and a low pin forces the mute request. Other behaviours show up only in the bench's transfer scenarios, which a per-clock model compares at the ports. These are address matching, the routing of the auto-increment and overwrite modes, discarding past register 8, the bit layout of the status byte and its refresh between bytes, and recovery after an aborted transfer.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int SUB_W   = 4;  // register selector width in the subaddress byte
  localparam int INC_BIT = 4;  // auto-increment flag position in the subaddress byte

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_SUB,
    S_DATA,
    S_READ,
    S_SKIP
  } bus_st_e;
endpackage

// File: rtl/acs_bus_sync.sv
module acs_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pin_n_i,
  output logic scl_s,
  output logic sda_s,
  output logic pin_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff, pin_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      pin_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      pin_ff <= {pin_ff[STAGES-2:0], pin_n_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign pin_s     = pin_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/acs_regbank.sv
module acs_regbank #(
  parameter int          NREG    = 9,
  parameter int          DW      = 8,
  parameter int          AW      = 4,
  parameter logic [7:0]  RST_VAL = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[i*DW +: DW] <= DW'(RST_VAL);
      else if (wr_en && wr_addr == AW'(i))
        regs_o[i*DW +: DW] <= wr_data;
    end
  end

  // R4: no write may target a register beyond the last one
  a_r4_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= AW'(NREG-1)));
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         NREG        = 9,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               smute_n_i,
  input  logic               smute_act_i,
  input  logic               zc_muted_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic               smute_req_o
);
  import acs_pkg::*;

  localparam int                CW       = $clog2(DW + 2);
  localparam logic [CW-1:0]     BYTE_END = CW'(DW);
  localparam logic [CW-1:0]     ACK_END  = CW'(DW + 1);
  localparam logic [SUB_W-1:0]  LAST     = SUB_W'(NREG - 1);
  localparam int                MUTE_BIT = (NREG - 1) * DW;

  logic scl_s, sda_s, pin_s, scl_rise, scl_fall, start_det, stop_det;

  acs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .pin_n_i(smute_n_i),
    .scl_s(scl_s), .sda_s(sda_s), .pin_s(pin_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_e          st;
  logic [CW-1:0]    cnt;
  logic [DW-1:0]    sh, rd_sh;
  logic             oe, rw, inc, ptr_ok;
  logic [SUB_W-1:0] ptr;
  logic             wr_en;
  logic [SUB_W-1:0] wr_addr;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    status;

  assign status = {{(DW-3){1'b0}}, smute_act_i, zc_muted_i, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rd_sh <= '0; oe <= 1'b0; rw <= 1'b0;
      inc <= 1'b0; ptr_ok <= 1'b0; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; oe <= 1'b0; ptr_ok <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; cnt <= '0; oe <= 1'b0;
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (scl_rise) begin
          if (cnt == BYTE_END) begin
            cnt <= ACK_END;
            if (st == S_READ && sda_s) st <= S_SKIP;  // master NACK
          end else begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
        end else if (scl_fall) begin
          if (cnt == BYTE_END) begin
            case (st)
              S_ADDR:
                if (sh[DW-1:1] == DEV_ADDR) begin oe <= 1'b1; rw <= sh[0]; end
                else st <= S_SKIP;
              S_SUB:
                if (sh[SUB_W-1:0] <= LAST) begin
                  oe <= 1'b1; ptr <= sh[SUB_W-1:0]; inc <= sh[INC_BIT]; ptr_ok <= 1'b1;
                end else st <= S_SKIP;
              S_DATA:
                if (ptr_ok) begin
                  oe <= 1'b1; wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                  if (inc) begin
                    if (ptr == LAST) ptr_ok <= 1'b0;
                    else             ptr    <= ptr + 1'b1;
                  end
                end else st <= S_SKIP;
              default: oe <= 1'b0;  // read: release for the master's ack bit
            endcase
          end else if (cnt == ACK_END) begin
            cnt <= '0;
            oe  <= 1'b0;
            case (st)
              S_ADDR:
                if (rw) begin st <= S_READ; rd_sh <= status; oe <= ~status[DW-1]; end
                else st <= S_SUB;
              S_SUB:  st <= S_DATA;
              S_READ: begin rd_sh <= status; oe <= ~status[DW-1]; end
              default: ;
            endcase
          end else if (st == S_READ && cnt != '0) begin
            oe    <= ~rd_sh[DW-2];
            rd_sh <= {rd_sh[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o = oe;

  acs_regbank #(.NREG(NREG), .DW(DW), .AW(SUB_W), .RST_VAL(8'hFE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) smute_req_o <= 1'b0;
    else     smute_req_o <= regs_o[MUTE_BIT] | ~pin_s;
  end

  // R1: once the transfer is being ignored the line is never pulled
  a_r1_silent_when_skipping: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP) |-> !oe);
  // R2: a STOP always returns the slave to idle with SDA released
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == S_IDLE && !oe));
  // R3: the register pointer never leaves the map while it is valid
  a_r3_ptr_in_map: assert property (@(posedge clk) disable iff (rst)
    ptr_ok |-> (ptr <= LAST));
  // R10: in write phases the line is pulled only right after the eighth bit
  a_r10_ack_slot_start: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe) && st != S_READ) |-> (cnt == BYTE_END));
  // R10: and released only when the ninth clock ends or the bus resets
  a_r10_ack_slot_end: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe) && st != S_READ) |-> (cnt == '0));
  // R9: a low pin forces the request on the following cycle
  a_r9_pin_forces_mute: assert property (@(posedge clk) disable iff (rst)
    !pin_s |=> smute_req_o);
endmodule

// File: tb/audio_ctl_i2c_slave_tb.sv
module audio_ctl_i2c_slave_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 5;   // system clocks per quarter bit
  localparam int NREG  = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic smute_n = 1'b1, sm_act = 1'b0, zc = 1'b0;
  logic sda_oe, smute_req;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  audio_ctl_i2c_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .smute_n_i(smute_n), .smute_act_i(sm_act), .zc_muted_i(zc),
    .regs_o(regs), .smute_req_o(smute_req)
  );

  int total = 0, bad = 0, prints = 0;
  logic [7:0] exp_r [NREG];
  logic settled = 1'b0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      if (prints < 40) $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      prints++;
    end
  endtask

  // per-clock reference comparison while no transfer is in flight
  always @(negedge clk) begin
    if (settled && !rst) begin
      for (int r = 0; r < NREG; r++)
        chk(regs[r*8 +: 8] == exp_r[r], "R4/R5 reg model", regs[r*8 +: 8], exp_r[r]);
      chk(smute_req == (exp_r[8][0] | ~smute_n), "R9 mute model", smute_req,
          exp_r[8][0] | ~smute_n);
      chk(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic v, output logic s);
    sda_m = v; cyc(Q); scl = 1'b1; cyc(Q); s = sda_line; cyc(Q); scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_start();
    settled = 1'b0;
    sda_m = 1'b1; scl = 1'b1; cyc(Q); sda_m = 1'b0; cyc(Q); scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(Q); scl = 1'b1; cyc(Q); sda_m = 1'b1; cyc(2*Q);
  endtask

  task automatic settle();
    cyc(6); settled = 1'b1; cyc(4);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, input logic nsm, input logic nzc, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); b[i] = s; end
    sm_act = nsm; zc = nzc;
    bit_x(~mack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] rb;
    for (int r = 0; r < NREG; r++) exp_r[r] = 8'hFE;
    cyc(5); rst = 1'b0; cyc(4);

    // R6 reset state
    for (int r = 0; r < NREG; r++) chk(regs[r*8 +: 8] == 8'hFE, "R6 reset value", regs[r*8 +: 8], 8'hFE);
    chk(smute_req == 1'b0, "R6 mute request after reset", smute_req, 0);
    chk(sda_oe == 1'b0, "R6 sda released", sda_oe, 0);
    settled = 1'b1; cyc(4);

    // R1 + R10: single write to volume register
    bus_start();
    wbyte(8'h88, a); chk(a, "R1 address ack", a, 1);
    wbyte(8'h02, a); chk(a, "R10 subaddress ack", a, 1);
    wbyte(8'h5A, a); chk(a, "R10 data ack", a, 1);
    bus_stop(); exp_r[2] = 8'h5A; settle();
    chk(regs[2*8 +: 8] == 8'h5A, "R1 write landed", regs[2*8 +: 8], 8'h5A);

    // R5 overwrite without auto-increment
    bus_start(); wbyte(8'h88, a); wbyte(8'h03, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); chk(a, "R5 third byte ack", a, 1);
    bus_stop(); exp_r[3] = 8'h33; settle();
    chk(regs[3*8 +: 8] == 8'h33 && regs[4*8 +: 8] == 8'hFE, "R5 same register", regs[3*8 +: 8], 8'h33);

    // R4 auto-increment across the whole map, then one too many
    bus_start(); wbyte(8'h88, a); wbyte(8'h10, a);
    for (int i = 0; i < NREG; i++) begin
      wbyte(8'hA0 + 8'(i), a); chk(a, "R4 burst ack", a, 1); exp_r[i] = 8'hA0 + 8'(i);
    end
    wbyte(8'h5C, a); chk(!a, "R4 byte past last register nacked", a, 0);
    bus_stop(); settle();
    chk(regs[8*8 +: 8] == 8'hA8, "R4 last register", regs[8*8 +: 8], 8'hA8);

    // R3 upper subaddress bits ignored
    bus_start(); wbyte(8'h88, a); wbyte(8'hE5, a); chk(a, "R3 high bits ignored ack", a, 1);
    wbyte(8'h3C, a); bus_stop(); exp_r[5] = 8'h3C; settle();
    chk(regs[5*8 +: 8] == 8'h3C, "R3 high bits ignored", regs[5*8 +: 8], 8'h3C);

    // R3 selector above 8
    bus_start(); wbyte(8'h88, a); wbyte(8'h09, a); chk(!a, "R3 bad selector nack", a, 0);
    wbyte(8'h00, a); chk(!a, "R3 rest ignored", a, 0);
    bus_stop(); settle();

    // R1 wrong address
    bus_start(); wbyte(8'h8A, a); chk(!a, "R1 wrong address nack", a, 0);
    wbyte(8'h01, a); chk(!a, "R1 ignored byte", a, 0);
    wbyte(8'h77, a); bus_stop(); settle();
    chk(regs[1*8 +: 8] == 8'hA1, "R1 no change", regs[1*8 +: 8], 8'hA1);

    // R9 mute from register and from pin
    bus_start(); wbyte(8'h88, a); wbyte(8'h08, a); wbyte(8'h01, a); bus_stop();
    exp_r[8] = 8'h01; settle();
    chk(smute_req == 1'b1, "R9 register bit", smute_req, 1);
    bus_start(); wbyte(8'h88, a); wbyte(8'h08, a); wbyte(8'h00, a); bus_stop();
    exp_r[8] = 8'h00; settle();
    chk(smute_req == 1'b0, "R9 cleared", smute_req, 0);
    settled = 1'b0; smute_n = 1'b0; settle();
    chk(smute_req == 1'b1, "R9 pin low", smute_req, 1);
    settled = 1'b0; smute_n = 1'b1; settle();

    // R7 + R8 status reads
    sm_act = 1'b1; zc = 1'b0;
    bus_start(); wbyte(8'h89, a); chk(a, "R1 read address ack", a, 1);
    rbyte(1'b1, 1'b0, 1'b1, rb); chk(rb == 8'h04, "R7 soft-mute flag bit 2", rb, 8'h04);
    rbyte(1'b1, 1'b1, 1'b1, rb); chk(rb == 8'h02, "R8 refreshed zero-cross bit 1", rb, 8'h02);
    rbyte(1'b0, 1'b0, 1'b0, rb); chk(rb == 8'h06, "R8 refreshed both", rb, 8'h06);
    rbyte(1'b0, 1'b0, 1'b0, rb); chk(rb == 8'hFF, "R8 silent after NACK", rb, 8'hFF);
    bus_stop(); settle();

    // R2 no START: SDA toggles while SCL low, then a byte is clocked
    settled = 1'b0; scl = 1'b0; cyc(Q);
    sda_m = 1'b0; cyc(Q); sda_m = 1'b1; cyc(Q);
    wbyte(8'h88, a); chk(!a, "R2 no start no ack", a, 0);
    scl = 1'b1; cyc(2*Q); settle();

    // R2 STOP aborts, new START works
    bus_start(); wbyte(8'h88, a); wbyte(8'h06, a); bus_stop(); settle();
    bus_start(); wbyte(8'h88, a); wbyte(8'h06, a); wbyte(8'h42, a);
    chk(a, "R2 fresh start ack", a, 1);
    bus_stop(); exp_r[6] = 8'h42; settle();
    chk(regs[6*8 +: 8] == 8'h42, "R2 write after abort", regs[6*8 +: 8], 8'h42);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule